// File: doc/BRIEF.md
# Partial Reconfiguration Engine Register Interface

This block is the host-facing register front end of a partial reconfiguration engine. A host on a 64-bit strobe bus uses it to reset the engine and wait for the acknowledge, choose the target region, and open a reconfiguration session. Inside the session the host streams 32-bit configuration words into an internal queue. It pushes a word only while the credit count in the status register shows free space. When the host marks the push as complete, the hardware ends the session on its own once the queue has drained. The host polls the start bit until it clears.

A downstream consumer drains the queue over a valid/ready stream, and it may report faults back on three fault lines. Faults, protocol misuse and queue overflow collect in a sticky error register. The host clears a bit by writing a one to it. A 128-bit read-only identifier, split across two registers, lets software check whether a bitstream fits the static design.

Top module: `prcfg_regif`

## Requirements
- R1: After rst_n is released, the control register (0x08) reads 0, the status register (0x10) reads credit = DEPTH with all other fields 0, the error register (0x20) reads 0, and cfg_valid is low.
- R2: Writing control bit 0 = 1 requests an engine reset. The acknowledge in control bit 4 then reads 1 for as long as bit 0 stays set, and it reads 0 once bit 0 is written back to 0. While the reset is held, the queue is flushed, start and complete are cleared, status bit 16 reads 0, and cfg_valid is low. The error register keeps its contents.
- R3: Control bits 9:7 hold the target region. They are written by every control write and read back unchanged.
- R4: Writing control bit 12 = 1 starts a session. Writing 0 to bit 12 has no effect. Status bit 16 reads 1 while the session is open.
- R5: A write to 0x18 during a session pushes bits 31:0 of the write data into the queue. Status bits 8:0 read DEPTH minus the queue occupancy, and the value is updated on the clock edge of each push or pop.
- R6: cfg_valid is high only while a session is open and the queue is non-empty. cfg_data presents the words in the order they were written. A word is consumed on each cycle in which cfg_valid and cfg_ready are both high.
- R7: Writing control bit 13 = 1 during a session sets complete. Once the queue is empty, the hardware clears both start and complete, and status bit 16 returns to 0.
- R8: Writing control bit 13 = 1 with no session open leaves complete at 0 and sets error bit 3 (protocol).
- R9: A write to 0x18 with no session open is dropped, leaving the credit unchanged, and sets error bit 3.
- R10: A write to 0x18 while the credit is 0 is dropped and sets error bit 4 (overflow).
- R11: Error bits are sticky. cfg_fault[0], cfg_fault[1] and cfg_fault[2] set error bits 0 (operation), 1 (CRC) and 2 (incompatible image). A write to 0x20 clears exactly the bits written as 1. A fault in the same cycle as the clear keeps its bit set.
- R12: Address 0xA8 reads the upper 64 bits of the identifier and 0xB0 reads the lower 64 bits.
- R13: bus_rdata holds the addressed register one cycle after a bus_rd strobe. Unmapped addresses and 0x18 read 0. Status bits 22:20 give the phase: 0 idle, 1 reset held, 2 streaming, 3 draining after complete. Status bits 27:24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after bus_rd |
| cfg_valid | output | 1 | Queue head is valid for the consumer |
| cfg_ready | input | 1 | Consumer accepts the head word |
| cfg_data | output | WW | Queue head configuration word |
| cfg_fault | input | 3 | Consumer fault pulses: operation, CRC, incompatible image |

## Verification
On every cycle, the assertions check the relation between the reset request and its acknowledge, that the stream is gated by the session and by queue occupancy, the credit range and the credit step on a push, the hardware end of a session after drain, the overflow capture, and the stickiness of the error bits. Only the bench scenarios can show things that depend on a whole sequence: word ordering through the queue, register read-back values and identifier contents, the drop of misplaced data writes as seen in an unchanged credit, the preservation of errors across an engine reset, and the selective write-one clear.

// File: rtl/prcfg_pkg.sv
package prcfg_pkg;
    // register byte offsets
    localparam logic [7:0] ADR_CTRL  = 8'h08;
    localparam logic [7:0] ADR_STAT  = 8'h10;
    localparam logic [7:0] ADR_DATA  = 8'h18;
    localparam logic [7:0] ADR_ERR   = 8'h20;
    localparam logic [7:0] ADR_ID_HI = 8'hA8;
    localparam logic [7:0] ADR_ID_LO = 8'hB0;

    // control bit positions
    localparam int CB_RST    = 0;
    localparam int CB_ACK    = 4;
    localparam int CB_RGN_LO = 7;
    localparam int CB_START  = 12;
    localparam int CB_DONE   = 13;

    // status bit positions
    localparam int SB_BUSY   = 16;
    localparam int SB_PH_LO  = 20;

    // error bit positions
    localparam int EB_OP       = 0;
    localparam int EB_CRC      = 1;
    localparam int EB_INCOMPAT = 2;
    localparam int EB_PROTO    = 3;
    localparam int EB_OVF      = 4;
    localparam int NERR        = 5;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_RESET  = 3'd1,
        PH_STREAM = 3'd2,
        PH_DRAIN  = 3'd3
    } phase_e;
endpackage

// File: rtl/prcfg_fifo.sv
module prcfg_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] credit
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fq_t;

    fq_t         st_d, st_q;
    logic        do_push, do_pop;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH)) && !flush;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push)
                st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            if (do_pop)
                st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            if (do_push && !do_pop)
                st_d.cnt = st_q.cnt + 1'b1;
            else if (do_pop && !do_push)
                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_data;
    end

    assign head   = mem[st_q.rp];
    assign empty  = (st_q.cnt == '0);
    assign full   = (st_q.cnt == CW'(DEPTH));
    assign credit = CW'(DEPTH) - st_q.cnt;
endmodule

// File: rtl/prcfg_ctrl.sv
module prcfg_ctrl
    import prcfg_pkg::*;
#(
    parameter int DW = 64,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          q_empty,
    output logic          rst_req,
    output logic          rst_ack,
    output logic [RW-1:0] region,
    output logic          start,
    output logic          done,
    output logic          proto_pulse,
    output phase_e        phase
);
    typedef struct packed {
        logic          rst_req;
        logic          ack;
        logic [RW-1:0] region;
        logic          start;
        logic          done;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        proto_pulse = 1'b0;
        st_d.ack    = st_q.rst_req;
        // session ends by itself once completion has drained the queue
        if (st_q.start && st_q.done && q_empty) begin
            st_d.start = 1'b0;
            st_d.done  = 1'b0;
        end
        if (wr_en) begin
            st_d.rst_req = wdata[CB_RST];
            st_d.region  = wdata[CB_RGN_LO +: RW];
            if (wdata[CB_START]) st_d.start = 1'b1;
            if (wdata[CB_DONE]) begin
                if (st_q.start && st_d.start) st_d.done = 1'b1;
                else if (!st_q.start)         proto_pulse = 1'b1;
            end
        end
        if (st_d.rst_req) begin
            st_d.start = 1'b0;
            st_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req = st_q.rst_req;
    assign rst_ack = st_q.ack && st_q.rst_req;
    assign region  = st_q.region;
    assign start   = st_q.start;
    assign done    = st_q.done;

    always_comb begin
        if (st_q.rst_req)   phase = PH_RESET;
        else if (st_q.done) phase = PH_DRAIN;
        else if (st_q.start) phase = PH_STREAM;
        else                phase = PH_IDLE;
    end
endmodule

// File: rtl/prcfg_err.sv
module prcfg_err #(
    parameter int NE = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] set,
    input  logic          clr_en,
    input  logic [NE-1:0] clr_mask,
    output logic [NE-1:0] err
);
    logic [NE-1:0] err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (clr_en) err_d = err_d & ~clr_mask;
        err_d = err_d | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err = err_q;
endmodule

// File: rtl/prcfg_regif.sv
module prcfg_regif
    import prcfg_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          DW        = 64,
    parameter int          WW        = 32,
    parameter int          DEPTH     = 256,
    parameter int          RW        = 3,
    parameter logic [63:0] IFC_ID_HI = 64'h5A5A_0001_C0DE_0002,
    parameter logic [63:0] IFC_ID_LO = 64'h0000_1111_2222_3333,
    localparam int         CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          cfg_valid,
    input  logic          cfg_ready,
    output logic [WW-1:0] cfg_data,
    input  logic [2:0]    cfg_fault
);
    logic          ctrl_we, data_we, err_we;
    logic          rst_req, rst_ack, start, done, proto_pulse;
    logic [RW-1:0] region;
    phase_e        phase;
    logic          fifo_empty, fifo_full, push, pop;
    logic [CW-1:0] credit;
    logic [NERR-1:0] err_set, err;
    logic [DW-1:0] rdata_d, rdata_q;
    logic [DW-1:0] ctrl_word, stat_word, err_word;

    assign ctrl_we = bus_wr && (bus_addr == AW'(ADR_CTRL));
    assign data_we = bus_wr && (bus_addr == AW'(ADR_DATA));
    assign err_we  = bus_wr && (bus_addr == AW'(ADR_ERR));

    prcfg_ctrl #(.DW(DW), .RW(RW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctrl_we),
        .wdata       (bus_wdata),
        .q_empty     (fifo_empty),
        .rst_req     (rst_req),
        .rst_ack     (rst_ack),
        .region      (region),
        .start       (start),
        .done        (done),
        .proto_pulse (proto_pulse),
        .phase       (phase)
    );

    assign push      = data_we && start && !fifo_full;
    assign cfg_valid = start && !fifo_empty;
    assign pop       = cfg_valid && cfg_ready;

    prcfg_fifo #(.DEPTH(DEPTH), .W(WW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rst_req),
        .push      (push),
        .push_data (bus_wdata[WW-1:0]),
        .pop       (pop),
        .head      (cfg_data),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .credit    (credit)
    );

    always_comb begin
        err_set              = '0;
        err_set[EB_OP]       = cfg_fault[0];
        err_set[EB_CRC]      = cfg_fault[1];
        err_set[EB_INCOMPAT] = cfg_fault[2];
        err_set[EB_PROTO]    = proto_pulse || (data_we && !start);
        err_set[EB_OVF]      = data_we && start && fifo_full;
    end

    prcfg_err #(.NE(NERR)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (err_set),
        .clr_en   (err_we),
        .clr_mask (bus_wdata[NERR-1:0]),
        .err      (err)
    );

    always_comb begin
        ctrl_word                   = '0;
        ctrl_word[CB_RST]           = rst_req;
        ctrl_word[CB_ACK]           = rst_ack;
        ctrl_word[CB_RGN_LO +: RW]  = region;
        ctrl_word[CB_START]         = start;
        ctrl_word[CB_DONE]          = done;

        stat_word                   = '0;
        stat_word[CW-1:0]           = credit;
        stat_word[SB_BUSY]          = start;
        stat_word[SB_PH_LO +: 3]    = phase;

        err_word                    = '0;
        err_word[NERR-1:0]          = err;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            unique case (bus_addr)
                AW'(ADR_CTRL):  rdata_d = ctrl_word;
                AW'(ADR_STAT):  rdata_d = stat_word;
                AW'(ADR_ERR):   rdata_d = err_word;
                AW'(ADR_ID_HI): rdata_d = DW'(IFC_ID_HI);
                AW'(ADR_ID_LO): rdata_d = DW'(IFC_ID_LO);
                default:        rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/prcfg_regif_chk.sv
module prcfg_regif_chk
    import prcfg_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 256,
    parameter int CW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic          rst_req,
    input logic          rst_ack,
    input logic          start,
    input logic          done,
    input logic          fifo_empty,
    input logic          cfg_valid,
    input logic          push,
    input logic          pop,
    input logic [CW-1:0] credit,
    input logic [NERR-1:0] err
);
    logic ctrl_wr, data_wr, err_wr;
    assign ctrl_wr = bus_wr && (bus_addr == AW'(ADR_CTRL));
    assign data_wr = bus_wr && (bus_addr == AW'(ADR_DATA));
    assign err_wr  = bus_wr && (bus_addr == AW'(ADR_ERR));

    p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ack |-> rst_req);

    p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !start && !cfg_valid);

    p_credit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CW'(DEPTH));

    p_credit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !rst_req) |=> (credit == $past(credit) - 1'b1));

    p_stream_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (start && !fifo_empty));

    p_drain_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done && fifo_empty && !ctrl_wr) |=> !start);

    p_overflow_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && start && credit == '0) |=> err[EB_OVF]);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !err_wr |=> ((err & $past(err)) == $past(err)));
endmodule

bind prcfg_regif prcfg_regif_chk #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .rst_req    (rst_req),
    .rst_ack    (rst_ack),
    .start      (start),
    .done       (done),
    .fifo_empty (fifo_empty),
    .cfg_valid  (cfg_valid),
    .push       (push),
    .pop        (pop),
    .credit     (credit),
    .err        (err)
);

// File: tb/tb_prcfg_regif.sv
module tb_prcfg_regif;
    localparam logic [63:0] IDH = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] IDL = 64'hFEDC_BA98_7654_3210;
    localparam int NV = 9;

    // {write, addr, wdata, expected read}
    localparam logic [136:0] TBL [NV] = '{
        {1'b0, 8'hA8, 64'h0,   IDH},
        {1'b0, 8'hB0, 64'h0,   IDL},
        {1'b1, 8'h08, 64'h280, 64'h0},
        {1'b0, 8'h08, 64'h0,   64'h280},
        {1'b0, 8'h10, 64'h0,   64'h100},
        {1'b0, 8'h40, 64'h0,   64'h0},
        {1'b1, 8'h08, 64'h100, 64'h0},
        {1'b0, 8'h08, 64'h0,   64'h100},
        {1'b0, 8'h20, 64'h0,   64'h0}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [63:0] bus_wdata = 0;
    logic [63:0] bus_rdata;
    logic        cfg_valid, cfg_ready = 0;
    logic [31:0] cfg_data;
    logic [2:0]  cfg_fault = 0;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    prcfg_regif #(.IFC_ID_HI(IDH), .IFC_ID_LO(IDL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
        .cfg_fault(cfg_fault)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(8'h08, v); chk("R1 ctrl", v, 64'h0);
        rd(8'h10, v); chk("R1 status", v, 64'h100);
        rd(8'h20, v); chk("R1 err", v, 64'h0);
        chk("R1 cfg_valid", 64'(cfg_valid), 64'h0);

        // table: R3 region, R12 id, R13 unmapped
        for (int i = 0; i < NV; i++) begin
            if (TBL[i][136]) wr(TBL[i][135:128], TBL[i][127:64]);
            else begin
                rd(TBL[i][135:128], v);
                case (TBL[i][135:128])
                    8'hA8, 8'hB0: chk("R12 id", v, TBL[i][63:0]);
                    8'h08:        chk("R3 region", v, TBL[i][63:0]);
                    default:      chk("R13 read", v, TBL[i][63:0]);
                endcase
            end
        end

        // R9 data with no session
        wr(8'h18, 64'h1234);
        rd(8'h20, v); chk("R9 proto", v, 64'h8);
        rd(8'h10, v); chk("R9 credit", v, 64'h100);
        wr(8'h20, 64'h8);
        rd(8'h20, v); chk("R11 clear", v, 64'h0);

        // R8 complete with no session
        wr(8'h08, 64'h2100);
        rd(8'h08, v); chk("R8 ctrl", v, 64'h100);
        rd(8'h20, v); chk("R8 proto", v, 64'h8);
        wr(8'h20, 64'h1F);

        // R4 start
        wr(8'h08, 64'h1100);
        rd(8'h08, v); chk("R4 ctrl", v, 64'h1100);
        rd(8'h10, v); chk("R4 status", v, 64'h210100);
        wr(8'h08, 64'h100);
        rd(8'h08, v); chk("R4 start kept", v, 64'h1100);

        // R5 / R6 push and stream
        wr(8'h18, 64'hFFFF_FFFF_AAAA_0001);
        wr(8'h18, 64'hBBBB_0002);
        wr(8'h18, 64'hCCCC_0003);
        rd(8'h10, v); chk("R5 credit", v, 64'h2100FD);
        chk("R6 valid", 64'(cfg_valid), 64'h1);
        chk("R6 head A", 64'(cfg_data), 64'hAAAA_0001);
        cfg_ready = 1;
        @(negedge clk);
        cfg_ready = 0;
        chk("R6 head B", 64'(cfg_data), 64'hBBBB_0002);
        rd(8'h10, v); chk("R5 credit pop", v, 64'h2100FE);

        // R7 completion
        wr(8'h08, 64'h3100);
        rd(8'h10, v); chk("R13 drain phase", v, 64'h3100FE);
        cfg_ready = 1;
        @(negedge clk);
        chk("R6 head C", 64'(cfg_data), 64'hCCCC_0003);
        repeat (4) @(negedge clk);
        cfg_ready = 0;
        rd(8'h08, v); chk("R7 ctrl", v, 64'h100);
        rd(8'h10, v); chk("R7 status", v, 64'h100);

        // R10 overflow
        wr(8'h08, 64'h1100);
        for (int k = 0; k < 256; k++) wr(8'h18, 64'(k));
        rd(8'h10, v); chk("R5 full", v, 64'h210000);
        wr(8'h18, 64'hDEAD);
        rd(8'h20, v); chk("R10 ovf", v, 64'h10);
        rd(8'h10, v); chk("R10 credit", v, 64'h210000);

        // R11 faults and selective clear
        @(negedge clk); cfg_fault = 3'b010;
        @(negedge clk); cfg_fault = 3'b000;
        rd(8'h20, v); chk("R11 fault", v, 64'h12);
        wr(8'h20, 64'h2);
        rd(8'h20, v); chk("R11 partial", v, 64'h10);

        // R2 engine reset
        wr(8'h08, 64'h101);
        rd(8'h08, v); chk("R2 ack", v, 64'h111);
        rd(8'h10, v); chk("R2 status", v, 64'h100100);
        chk("R2 cfg_valid", 64'(cfg_valid), 64'h0);
        rd(8'h20, v); chk("R2 err kept", v, 64'h10);
        wr(8'h08, 64'h100);
        rd(8'h08, v); chk("R2 release", v, 64'h100);
        wr(8'h20, 64'h10);
        rd(8'h20, v); chk("R11 clear ovf", v, 64'h0);

        finished = 1;
        summary();
    end
endmodule